// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction must fire. It receives two operands, a five-bit condition mask and a size select. It compares the operands as signed numbers and as unsigned numbers. Each relation that holds is gated by its own mask bit. If any gated relation survives, the block raises a trap request and attaches the program-exception subcode for a trap.

The size select picks the operand width. In word mode only the lower half of each operand is compared, with the sign taken from bit 31. In doubleword mode the full width is used. Requests enter through a valid/ready handshake. Each accepted request produces exactly one registered result one cycle later. A result that the consumer has not yet taken holds the input off.

Top module: `trap_cmp_unit`

## Requirements
- R1: Mask bit 4 (0x10) enables a trap when operand A is less than operand B as two's-complement numbers; trap_hits bit 4 shows that this relation fired.
- R2: Mask bit 3 (0x08) enables a trap when A is greater than B as two's-complement numbers; trap_hits bit 3 shows it.
- R3: Mask bit 2 (0x04) enables a trap when A equals B; trap_hits bit 2 shows it. At most one of the signed-less, signed-greater and equal hits is ever set, and unsigned-less and unsigned-greater are never set together.
- R4: Mask bit 1 (0x02) enables a trap on unsigned A < B, and mask bit 0 (0x01) enables a trap on unsigned A > B; these appear on trap_hits bits 1 and 0.
- R5: With dword low, only bits 31:0 of each operand take part, and bit 31 is the sign; bits 63:32 have no effect on the result.
- R6: With dword high, all 64 bits are compared, and bit 63 is the sign.
- R7: trap_req is high exactly when trap_hits is non-zero, where trap_hits is the condition mask ANDed with the relations that hold.
- R8: A condition mask of 0x1F traps for every operand pair, and a mask of 0x00 never traps.
- R9: trap_subcode equals the TRAP_CODE parameter (default 4'h2) whenever trap_req is high, and is zero otherwise.
- R10: A request is accepted on a rising edge where req_valid and req_ready are both high. Its result and trap_valid appear after that edge, and remain until a later edge where rsp_ready is high.
- R11: While trap_valid is high and rsp_ready is low, the result holds steady and req_ready is low. When rsp_ready is high, a new request can be accepted on the same edge that retires the old result.
- R12: After reset, and whenever trap_valid is low, trap_valid, trap_req, trap_hits and trap_subcode are all zero, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cond | input | 5 | Relation enable mask |
| dword | input | 1 | 1: 64-bit compare, 0: 32-bit compare |
| trap_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| trap_req | output | 1 | Trap must be taken |
| trap_subcode | output | 4 | Program-exception subcode, zero when no trap |
| trap_hits | output | 5 | Mask ANDed with the relations that hold |

## Verification
The bench targets operands where signed and unsigned order disagree. It uses a negative value against one, and the most negative value against the most positive. A design that mixed the two orderings would report the wrong hit bit for these pairs. Word-mode vectors carry upper halves that, if they were compared, would flip the result or break equality, so a design that leaked those bits would be caught. Back-pressure tests hold rsp_ready low while a different request waits at the input; a design that overwrote or dropped the pending result would show changed values or a lost response.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int COND_W  = 5;
  localparam int SLT_BIT = 4;
  localparam int SGT_BIT = 3;
  localparam int EQ_BIT  = 2;
  localparam int ULT_BIT = 1;
  localparam int UGT_BIT = 0;

  typedef logic [COND_W-1:0] rel_vec_t;
endpackage

// File: rtl/trap_rel_cmp.sv
module trap_rel_cmp #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  logic               dword,
  output trap_pkg::rel_vec_t rel
);
  localparam int EXT_W = DATA_W + 1;

  // Extend an operand by one bit so that one signed compare covers both sizes.
  function automatic logic [EXT_W-1:0] widen(input logic [DATA_W-1:0] v,
                                             input logic dw, input logic sgn);
    logic top;
    logic [EXT_W-1:0] r;
    top = dw ? v[DATA_W-1] : v[WORD_W-1];
    if (dw) r = {sgn & top, v};
    else    r = {{(EXT_W-WORD_W){sgn & top}}, v[WORD_W-1:0]};
    return r;
  endfunction

  logic [EXT_W-1:0] sa, sb, ua, ub;

  always_comb begin
    sa = widen(a, dword, 1'b1);
    sb = widen(b, dword, 1'b1);
    ua = widen(a, dword, 1'b0);
    ub = widen(b, dword, 1'b0);
    rel = '0;
    rel[trap_pkg::SLT_BIT] = $signed(sa) < $signed(sb);
    rel[trap_pkg::SGT_BIT] = $signed(sa) > $signed(sb);
    rel[trap_pkg::EQ_BIT]  = ua == ub;
    rel[trap_pkg::ULT_BIT] = ua < ub;
    rel[trap_pkg::UGT_BIT] = ua > ub;
  end
endmodule

// File: rtl/trap_cond_mask.sv
module trap_cond_mask #(
  parameter int               CODE_W    = 4,
  parameter logic [CODE_W-1:0] TRAP_CODE = 4'h2
) (
  input  trap_pkg::rel_vec_t rel,
  input  trap_pkg::rel_vec_t cond,
  output trap_pkg::rel_vec_t hits,
  output logic               trap,
  output logic [CODE_W-1:0]  code
);
  always_comb begin
    hits = rel & cond;
    trap = |hits;
    code = trap ? TRAP_CODE : '0;
  end
endmodule

// File: rtl/trap_rsp_stage.sv
module trap_rsp_stage #(
  parameter int CODE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  trap_pkg::rel_vec_t in_hits,
  input  logic               in_trap,
  input  logic [CODE_W-1:0]  in_code,
  output logic               out_valid,
  input  logic               out_ready,
  output trap_pkg::rel_vec_t out_hits,
  output logic               out_trap,
  output logic [CODE_W-1:0]  out_code
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hits  <= '0;
      out_trap  <= 1'b0;
      out_code  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_hits  <= in_hits;
      out_trap  <= in_trap;
      out_code  <= in_code;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_hits  <= '0;
      out_trap  <= 1'b0;
      out_code  <= '0;
    end
  end
endmodule

// File: rtl/trap_cmp_unit.sv
module trap_cmp_unit #(
  parameter int                DATA_W    = 64,
  parameter int                WORD_W    = 32,
  parameter int                CODE_W    = 4,
  parameter logic [CODE_W-1:0] TRAP_CODE = 4'h2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [DATA_W-1:0]          op_a,
  input  logic [DATA_W-1:0]          op_b,
  input  logic [trap_pkg::COND_W-1:0] cond,
  input  logic                       dword,
  output logic                       trap_valid,
  input  logic                       rsp_ready,
  output logic                       trap_req,
  output logic [CODE_W-1:0]          trap_subcode,
  output logic [trap_pkg::COND_W-1:0] trap_hits
);
  trap_pkg::rel_vec_t rel_now, hits_now;
  logic               trap_now;
  logic [CODE_W-1:0]  code_now;
  logic               req_fire;

  assign req_fire = req_valid && req_ready;

  trap_rel_cmp #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_cmp (
    .a(op_a), .b(op_b), .dword(dword), .rel(rel_now)
  );

  trap_cond_mask #(.CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)) u_mask (
    .rel(rel_now), .cond(cond), .hits(hits_now), .trap(trap_now), .code(code_now)
  );

  trap_rsp_stage #(.CODE_W(CODE_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_hits(hits_now), .in_trap(trap_now), .in_code(code_now),
    .out_valid(trap_valid), .out_ready(rsp_ready),
    .out_hits(trap_hits), .out_trap(trap_req), .out_code(trap_subcode)
  );
endmodule

// File: rtl/trap_cmp_chk.sv
module trap_cmp_chk #(
  parameter int                CODE_W    = 4,
  parameter logic [CODE_W-1:0] TRAP_CODE = 4'h2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_fire,
  input logic                        req_ready,
  input logic                        trap_valid,
  input logic                        rsp_ready,
  input logic                        trap_req,
  input logic [CODE_W-1:0]           trap_subcode,
  input logic [trap_pkg::COND_W-1:0] trap_hits
);
  import trap_pkg::*;

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && !rsp_ready |=> trap_valid && $stable(trap_req) &&
      $stable(trap_hits) && $stable(trap_subcode));

  assert_stall_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && !rsp_ready |-> !req_ready);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> trap_valid);

  assert_retire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_fire && trap_valid && rsp_ready |=> !trap_valid);

  assert_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> trap_subcode == (trap_req ? TRAP_CODE : '0));

  assert_reduce_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req == (trap_hits != '0));

  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $countones({trap_hits[SLT_BIT], trap_hits[SGT_BIT], trap_hits[EQ_BIT]}) <= 1 &&
      !(trap_hits[ULT_BIT] && trap_hits[UGT_BIT]));

  assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |-> !trap_req && trap_hits == '0 && trap_subcode == '0 && req_ready);
endmodule

bind trap_cmp_unit trap_cmp_chk #(.CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_ready(req_ready),
  .trap_valid(trap_valid), .rsp_ready(rsp_ready), .trap_req(trap_req),
  .trap_subcode(trap_subcode), .trap_hits(trap_hits)
);

// File: tb/tb_trap_cmp_unit.sv
module tb_trap_cmp_unit;
  localparam int NV = 14;
  localparam logic [3:0] CODE = 4'h2;

  // {op_a, op_b, cond, dword, expected hits}
  localparam logic [139:0] VEC [NV] = '{
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h1F, 1'b1, 5'b10001},
    {64'h5, 64'h5, 5'h1F, 1'b1, 5'b00100},
    {64'h3, 64'h7, 5'h1F, 1'b1, 5'b10010},
    {64'h7, 64'h3, 5'h00, 1'b1, 5'b00000},
    {64'h7, 64'h3, 5'h08, 1'b1, 5'b01000},
    {64'h7, 64'h3, 5'h10, 1'b1, 5'b00000},
    {64'hFFFF_FFFF_0000_0005, 64'h5, 5'h1F, 1'b0, 5'b00100},
    {64'hFFFF_FFFF_0000_0005, 64'h5, 5'h1F, 1'b1, 5'b10001},
    {64'h0000_0000_8000_0000, 64'h1, 5'h1F, 1'b0, 5'b10001},
    {64'h0000_0000_8000_0000, 64'h1, 5'h1F, 1'b1, 5'b01001},
    {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 5'h1F, 1'b1, 5'b10001},
    {64'h1, 64'h2, 5'h02, 1'b1, 5'b00010},
    {64'h1, 64'h2, 5'h01, 1'b1, 5'b00000},
    {64'h1234_5678_0000_0002, 64'hABCD_0000_0000_0001, 5'h09, 1'b0, 5'b01001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1, dword = 1'b1;
  logic [63:0] op_a = '0, op_b = '0;
  logic [4:0] cond = '0;
  logic req_ready, trap_valid, trap_req;
  logic [3:0] trap_subcode;
  logic [4:0] trap_hits;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trap_cmp_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .op_a(op_a), .op_b(op_b), .cond(cond), .dword(dword),
    .trap_valid(trap_valid), .rsp_ready(rsp_ready), .trap_req(trap_req),
    .trap_subcode(trap_subcode), .trap_hits(trap_hits)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_result(input string tag, input logic [4:0] hits);
    check({tag, " valid R10"}, 64'(trap_valid), 64'd1);
    check({tag, " hits R1 R2 R3 R4"}, 64'(trap_hits), 64'(hits));
    check({tag, " trap R7"}, 64'(trap_req), 64'(|hits));
    check({tag, " subcode R9"}, 64'(trap_subcode), (|hits) ? 64'(CODE) : 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("reset valid R12", 64'(trap_valid), 64'd0);
    check("reset trap R12", 64'(trap_req), 64'd0);
    check("reset ready R12", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {op_a, op_b, cond, dword} = VEC[i][139:5];
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check_result($sformatf("vec%0d R5 R6", i), VEC[i][4:0]);
    end
    @(negedge clk);
    check("retire R10", 64'(trap_valid), 64'd0);

    // R8: full mask on several pairs, empty mask on the same pairs
    for (int k = 0; k < 3; k++) begin
      op_a = 64'(k) << 40; op_b = 64'h10; dword = k[0];
      cond = 5'h1F; req_valid = 1'b1;
      @(negedge clk);
      check("full mask R8", 64'(trap_req), 64'd1);
      cond = 5'h00;
      @(negedge clk);
      req_valid = 1'b0;
      check("empty mask R8", 64'(trap_req), 64'd0);
    end
    @(negedge clk);

    // R11: back-pressure with a different request waiting
    rsp_ready = 1'b0;
    op_a = 64'h9; op_b = 64'h9; cond = 5'h04; dword = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    op_a = 64'h1; op_b = 64'h9; cond = 5'h12;
    for (int s = 0; s < 3; s++) begin
      check("stall ready R11", 64'(req_ready), 64'd0);
      check_result("stall hold R11", 5'b00100);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_result("swap R11", 5'b10010);
    @(negedge clk);
    check("drain R12", 64'(trap_valid), 64'd0);

    // R12: mid-run reset clears a pending result
    rsp_ready = 1'b0; op_a = 64'h2; op_b = 64'h2; cond = 5'h04; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("async reset R12", 64'(trap_valid), 64'd0);
    check("async reset trap R12", 64'(trap_req), 64'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule